// File: doc/BRIEF.md
# Packed GPIO Configuration Bank

This block holds the configuration of a set of general-purpose pins behind a Wishbone slave port. Each pin owns one 8-bit configuration byte. The bytes are packed into data words, so one word carries as many pins as it has byte lanes. The byte of lane `l` at word address `a` belongs to pin `a * LANES + l`, where `LANES = DATA_W / 8`. From its byte, each pin drives an output level, an output enable, a pull-up enable, a pull-down enable and a 3-bit bank select toward the pad ring. The block also samples the pad input, so that software can read it back.

Software uses single Wishbone transfers. The bus side has no stall and no back-pressure. A master raises `cyc` and `stb` and holds them until it sees `ack`. `ack` comes exactly one clock after the request is seen, and write data is taken on that same edge. Lane selects give byte-granular writes and masked reads. Addresses past the last populated row, and lanes past the last pin in a partial row, behave as empty space.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset every configuration byte is zero. All pad outputs (`pad_o`, `pad_oe`, `pad_pu`, `pad_pd`, `pad_bank`) are low, and `wb_ack` and `wb_dat_r` are zero.
- R2: `wb_ack` is high for exactly one cycle, one clock after a cycle in which `wb_cyc` and `wb_stb` are both high and `wb_ack` is low. It is never high otherwise, and `wb_stb` alone or `wb_cyc` alone never produces it.
- R3: A write stores bits `[8l+7:8l]` of `wb_dat_w` into pin `wb_adr*LANES + l` only for lanes whose `wb_sel[l]` is 1. Pins in unselected lanes, and in other rows, keep their bytes.
- R4: The byte layout is: bit 0 = I/O level, bit 1 = output enable, bit 2 = input enable, bit 3 = pull-up, bit 4 = pull-down, bits 7:5 = bank select. The pins `pad_o`, `pad_oe`, `pad_pu`, `pad_pd` and `pad_bank[3g+2:3g]` of pin `g` follow these fields.
- R5: A read returns, in each lane whose `wb_sel` bit is 1, that pin's byte. Each lane whose `wb_sel` bit is 0 returns zero.
- R6: In read data, bit 0 of a pin's byte is the stored output level when that pin's output enable is 1. When the output enable is 0, bit 0 is the value of `pad_i` in the request cycle.
- R7: The input-enable bit is stored and reads back, but it has no effect on any pad output.
- R8: Rows at or beyond `ceil(NUM_GPIO/LANES)`, and lanes whose pin index is `NUM_GPIO` or more, read as zero. Writes to them change nothing.
- R9: `wb_dat_r` is zero in every cycle except the `ack` cycle of a read.
- R10: `pad_o` follows the stored level even while the output enable is 0, so that a later enable drives the level last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Transfer strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_adr | input | ADR_W | Word (row) address |
| wb_sel | input | DATA_W/8 | Byte-lane selects, one per pin in the row |
| wb_dat_w | input | DATA_W | Write data |
| wb_dat_r | output | DATA_W | Read data, valid with `wb_ack` |
| wb_ack | output | 1 | Transfer acknowledge |
| pad_i | input | NUM_GPIO | Pad input levels |
| pad_o | output | NUM_GPIO | Output level per pin |
| pad_oe | output | NUM_GPIO | Output enable per pin |
| pad_pu | output | NUM_GPIO | Pull-up enable per pin |
| pad_pd | output | NUM_GPIO | Pull-down enable per pin |
| pad_bank | output | 3*NUM_GPIO | Bank select, 3 bits per pin |

## Verification
Two functions can meet in one cycle. The bus samples the read-back byte, and the pad input changes. The bench drives a new `pad_i` value in the same cycle as a read request to input-configured pins. It expects the new level in bit 0 of those lanes, and the stored level in the lanes whose output is enabled. A held strobe also makes a second request arrive in the cycle right after an acknowledge. The bench judges this by watching `ack` alternate, rather than stay high.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int CFG_W  = 8;
  localparam int BANK_W = 3;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic              pden;
    logic              puen;
    logic              ie;
    logic              oe;
    logic              io;
  } cfg_t;
endpackage

// File: rtl/gpio_cfg_bus.sv
module gpio_cfg_bus #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [LANES-1:0] sel,
  output logic             ack,
  output logic [LANES-1:0] wr_lane,
  output logic             rd_fire
);
  logic fire;

  assign fire    = cyc & stb & ~ack;
  assign wr_lane = {LANES{fire & we}} & sel;
  assign rd_fire = fire & ~we;

  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= fire;
  end

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(cyc && stb)); // R2
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R2
endmodule

// File: rtl/gpio_cfg_cell.sv
module gpio_cfg_cell
  import gpio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_byte,
  input  logic              pad_in,
  output logic              out_lvl,
  output logic              out_en,
  output logic              pull_up,
  output logic              pull_dn,
  output logic [BANK_W-1:0] bank,
  output logic [CFG_W-1:0]  rd_byte
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_t'(wr_byte);
  end

  assign out_lvl = cfg_q.io;
  assign out_en  = cfg_q.oe;
  assign pull_up = cfg_q.puen;
  assign pull_dn = cfg_q.pden;
  assign bank    = cfg_q.bank;

  // output pins read back their stored level; inputs show the live pad
  assign rd_byte = {cfg_q.bank, cfg_q.pden, cfg_q.puen, cfg_q.ie, cfg_q.oe,
                    (cfg_q.oe ? cfg_q.io : pad_in)};

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/gpio_cfg_rdpath.sv
module gpio_cfg_rdpath #(
  parameter int LANES    = 4,
  parameter int NUM_GPIO = 14,
  parameter int ADR_W    = 3,
  localparam int DATA_W  = LANES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_fire,
  input  logic [ADR_W-1:0]      adr,
  input  logic [LANES-1:0]      sel,
  input  logic [NUM_GPIO*8-1:0] rd_bytes,
  output logic [DATA_W-1:0]     dat_r
);
  logic [DATA_W-1:0] gathered;

  always_comb begin
    gathered = '0;
    for (int l = 0; l < LANES; l++) begin
      int idx;
      idx = int'(adr) * LANES + l;
      if (sel[l] && idx < NUM_GPIO)
        gathered[l*8 +: 8] = rd_bytes[idx*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       dat_r <= '0;
    else if (rd_fire) dat_r <= gathered;
    else              dat_r <= '0;
  end

  AST_RD_UNSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !sel[0]) |=> (dat_r[7:0] == 8'h00)); // R5
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_GPIO = 14,
  parameter int DATA_W   = 32,
  parameter int ADR_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wb_cyc,
  input  logic                         wb_stb,
  input  logic                         wb_we,
  input  logic [ADR_W-1:0]             wb_adr,
  input  logic [DATA_W/8-1:0]          wb_sel,
  input  logic [DATA_W-1:0]            wb_dat_w,
  output logic [DATA_W-1:0]            wb_dat_r,
  output logic                         wb_ack,
  input  logic [NUM_GPIO-1:0]          pad_i,
  output logic [NUM_GPIO-1:0]          pad_o,
  output logic [NUM_GPIO-1:0]          pad_oe,
  output logic [NUM_GPIO-1:0]          pad_pu,
  output logic [NUM_GPIO-1:0]          pad_pd,
  output logic [BANK_W*NUM_GPIO-1:0]   pad_bank
);
  localparam int LANES = DATA_W / CFG_W;
  localparam int ROWS  = (NUM_GPIO + LANES - 1) / LANES;

  logic [LANES-1:0]          wr_lane;
  logic                      rd_fire;
  logic [NUM_GPIO*CFG_W-1:0] rd_bytes;

  gpio_cfg_bus #(.LANES(LANES)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc     (wb_cyc),
    .stb     (wb_stb),
    .we      (wb_we),
    .sel     (wb_sel),
    .ack     (wb_ack),
    .wr_lane (wr_lane),
    .rd_fire (rd_fire)
  );

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
    localparam int ROW  = g / LANES;
    localparam int LANE = g % LANES;
    logic wr_en;

    assign wr_en = wr_lane[LANE] && (wb_adr == ADR_W'(ROW));

    gpio_cfg_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_byte (wb_dat_w[LANE*CFG_W +: CFG_W]),
      .pad_in  (pad_i[g]),
      .out_lvl (pad_o[g]),
      .out_en  (pad_oe[g]),
      .pull_up (pad_pu[g]),
      .pull_dn (pad_pd[g]),
      .bank    (pad_bank[g*BANK_W +: BANK_W]),
      .rd_byte (rd_bytes[g*CFG_W +: CFG_W])
    );
  end

  gpio_cfg_rdpath #(
    .LANES    (LANES),
    .NUM_GPIO (NUM_GPIO),
    .ADR_W    (ADR_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .adr      (wb_adr),
    .sel      (wb_sel),
    .rd_bytes (rd_bytes),
    .dat_r    (wb_dat_r)
  );

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_ack |-> (wb_dat_r == '0)); // R9
  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_stb && wb_we && (int'(wb_adr) >= ROWS)) |=>
      ($stable(pad_o) && $stable(pad_oe) && $stable(pad_pu) &&
       $stable(pad_pd) && $stable(pad_bank))); // R8
endmodule

// File: tb/tb_gpio_cfg_bank.sv
module tb_gpio_cfg_bank;
  localparam int NG = 14;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [AW-1:0] wb_adr = '0;
  logic [3:0]    wb_sel = '0;
  logic [DW-1:0] wb_dat_w = '0;
  logic [DW-1:0] wb_dat_r;
  logic          wb_ack;
  logic [NG-1:0] pad_i = '0;
  logic [NG-1:0] pad_o, pad_oe, pad_pu, pad_pd;
  logic [3*NG-1:0] pad_bank;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  gpio_cfg_bank #(.NUM_GPIO(NG), .DATA_W(DW), .ADR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
    .wb_ack(wb_ack), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_bank(pad_bank)
  );

  typedef struct packed {
    logic          we;
    logic [AW-1:0] adr;
    logic [3:0]    sel;
    logic [DW-1:0] wd;
    logic [NG-1:0] pad;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 4'hF, 32'h11E40A03, 14'h0000, 32'h00000000}, // R3 R9
    '{1'b0, 3'd0, 4'hF, 32'h0,        14'h0000, 32'h10E40A03}, // R4 R6 R7
    '{1'b0, 3'd0, 4'hF, 32'h0,        14'h000F, 32'h11E50A03}, // R6
    '{1'b0, 3'd0, 4'h5, 32'h0,        14'h0000, 32'h00E40003}, // R5
    '{1'b1, 3'd1, 4'h6, 32'hFF5BA2FF, 14'h0000, 32'h00000000}, // R3
    '{1'b0, 3'd1, 4'hF, 32'h0,        14'h0000, 32'h005BA200}, // R3
    '{1'b1, 3'd3, 4'hF, 32'h7766C381, 14'h0000, 32'h00000000}, // R8
    '{1'b0, 3'd3, 4'hF, 32'h0,        14'h0000, 32'h0000C380}, // R8
    '{1'b0, 3'd3, 4'hF, 32'h0,        14'h1000, 32'h0000C381}, // R6
    '{1'b1, 3'd5, 4'hF, 32'hFFFFFFFF, 14'h0000, 32'h00000000}, // R8
    '{1'b0, 3'd5, 4'hF, 32'h0,        14'h0000, 32'h00000000}, // R8
    '{1'b0, 3'd0, 4'hF, 32'h0,        14'h0000, 32'h10E40A03}, // R8
    '{1'b1, 3'd0, 4'h2, 32'h00000000, 14'h0000, 32'h00000000}, // R3
    '{1'b0, 3'd0, 4'hF, 32'h0,        14'h0000, 32'h10E40003}  // R3
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [AW-1:0] adr, input logic [3:0] sel,
                     input logic [DW-1:0] wd, input logic [NG-1:0] pad,
                     output logic [DW-1:0] rd, output logic ackd);
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_sel = sel;
    wb_dat_w = wd; pad_i = pad;
    @(negedge clk);
    ackd = wb_ack;
    rd = wb_dat_r;
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic ackd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs", {pad_o, pad_oe, pad_pu, pad_pd, 8'h00}, 64'h0);
    check("R1 bank/ack/data", {pad_bank, wb_ack, 21'h0}, 64'h0);
    check("R1 rdata", {32'h0, wb_dat_r}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].we, VECS[i].adr, VECS[i].sel, VECS[i].wd, VECS[i].pad, rd, ackd);
      check($sformatf("R5/R9 vector %0d", i), {31'h0, ackd, rd}, {31'h0, 1'b1, VECS[i].exp});
    end

    // pins after the table (R4, R7 ie on pin 2 drives nothing, R10 pin 3 level while disabled)
    check("R4 pad_oe", 64'(pad_oe), 64'h2061);
    check("R10 pad_o", 64'(pad_o), 64'h3049);
    check("R4 pad_pu", 64'(pad_pu), 64'h0040);
    check("R4 pad_pd", 64'(pad_pd), 64'h0048);
    check("R4 bank pin2", 64'(pad_bank[8:6]), 64'd7);
    check("R4 bank pin5", 64'(pad_bank[17:15]), 64'd5);
    check("R4 bank pin13", 64'(pad_bank[41:39]), 64'd6);
    check("R7 pin2 pins", {61'h0, pad_o[2], pad_oe[2], pad_pu[2]}, 64'h0);

    // R10: enabling pin 3 drives the level written earlier
    bus(1'b1, 3'd0, 4'h8, 32'h13000000, '0, rd, ackd);
    check("R10 enable pin3", {62'h0, pad_oe[3], pad_o[3]}, 64'h3);

    // R2 ack timing with a held strobe
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = 3'd0; wb_sel = 4'h0;
    @(negedge clk);
    check("R2 ack first", 64'(wb_ack), 64'h1);
    check("R5 sel none", 64'(wb_dat_r), 64'h0);
    @(negedge clk);
    check("R2 ack drops", 64'(wb_ack), 64'h0);
    @(negedge clk);
    check("R2 ack again", 64'(wb_ack), 64'h1);
    wb_stb = 1'b0;
    @(negedge clk);
    check("R2 cyc alone", 64'(wb_ack), 64'h0);
    @(negedge clk);
    check("R2 cyc alone 2", 64'(wb_ack), 64'h0);
    wb_cyc = 1'b0; wb_stb = 1'b1;
    @(negedge clk);
    check("R2 stb alone", 64'(wb_ack), 64'h0);
    check("R9 idle data", 64'(wb_dat_r), 64'h0);
    wb_stb = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule